// File: doc/BRIEF.md
# Long-Mode Control Register Unit

This unit holds the processor control state that governs entry into and exit from long mode. It stores the paging and protection control word (CR0), the page-table base (CR3), the extension control word (CR4), the extended feature register, and the current code-segment long bit. A single write port delivers one request per cycle. Each request carries a target select, an MSR number that is used only by the extended-register path, and a 64-bit value.

Each write is checked against the rules for switching long mode before it is committed. A write that breaks a rule raises a general-protection fault pulse in the same cycle, and that write changes nothing. A write that passes every check is applied on the next clock edge. The long-mode-active flag is derived by the unit itself: it is set when paging is switched on with long mode enabled, and cleared when paging is switched off. A page-base write that is made outside 64-bit mode is cut down to its low 32 bits.

Top module: `lmode_ctl_unit`

## Requirements
- R1: While reset is asserted, cr0_o reads 0x10. cr3_o, cr4_o, efer_o and cs_l_o read zero, and gp_fault_o is 0.
- R2: wr_sel_i encodes the target as 0 = CR0, 1 = CR3, 2 = CR4, 3 = MSR, 4 = code-segment long bit (taken from wr_data_i bit 0). An MSR write reaches the extended register only when wr_msr_i is 0xC0000080. Any other MSR number changes nothing and raises no fault. An accepted write appears on the outputs after the next rising clock edge.
- R3: A write to the extended register that changes long-mode enable (bit 8) while CR0 paging (bit 31) is 1 faults, in either direction. A write that leaves bit 8 unchanged does not fault.
- R4: A CR0 write that takes paging from 0 to 1 faults when long-mode enable is 1 and CR4 address extension (bit 5) is 0.
- R5: A CR0 write that takes paging from 0 to 1 faults when long-mode enable is 1 and the code-segment long bit is 1.
- R6: A CR4 write that takes address extension from 1 to 0 faults while long-mode-active is 1.
- R7: Long-mode-active is bit 10 of efer_o. An accepted CR0 write that takes paging from 0 to 1 loads this bit from long-mode enable. An accepted CR0 write with paging 0 clears it. Software writes to bit 10 are ignored.
- R8: 64-bit mode is long-mode-active and code-segment long bit both 1, shown on mode64_o. A CR3 write stores all 64 bits in 64-bit mode. Outside 64-bit mode it stores the low 32 bits and zeroes the upper 32.
- R9: gp_fault_o is high only in a cycle in which wr_valid_i is high and the request breaks a rule. A faulting write leaves every register unchanged.
- R10: Whenever long-mode-active is 1, paging, long-mode enable and address extension are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request valid |
| wr_sel_i | input | 3 | Write target select |
| wr_msr_i | input | 32 | MSR number for select 3 |
| wr_data_i | input | 64 | Write value |
| cr0_o | output | 64 | CR0 contents |
| cr3_o | output | 64 | CR3 contents |
| cr4_o | output | 64 | CR4 contents |
| efer_o | output | 64 | Extended feature register, bit 10 is long-mode-active |
| cs_l_o | output | 1 | Code-segment long bit |
| mode64_o | output | 1 | 64-bit mode indication |
| gp_fault_o | output | 1 | Fault pulse for a rejected write |

## Verification
Faults are combinational, so a rule that is wrongly decoded shows on gp_fault_o in the very cycle of the offending write. A wrong long-mode-active value shows on efer_o bit 10 and mode64_o one edge after the CR0 write that should have set or cleared it. It then shows again through the CR3 mask on the next page-base write. A write that is committed when it should have been rejected shows as a changed register one edge later. The bench compares every register after every write, so the error is caught at the first edge where it becomes visible.

// File: rtl/lmode_pkg.sv
package lmode_pkg;

  localparam int unsigned CR0_PE_BIT  = 0;
  localparam int unsigned CR0_PG_BIT  = 31;
  localparam int unsigned CR4_PAE_BIT = 5;
  localparam int unsigned EFER_LME_BIT = 8;
  localparam int unsigned EFER_LMA_BIT = 10;

  typedef enum logic [2:0] {
    SEL_CR0 = 3'd0,
    SEL_CR3 = 3'd1,
    SEL_CR4 = 3'd2,
    SEL_MSR = 3'd3,
    SEL_CSL = 3'd4
  } wr_sel_e;

  typedef struct packed {
    logic cr0;
    logic cr3;
    logic cr4;
    logic efer;
    logic csl;
  } wr_hit_t;

endpackage

// File: rtl/lmode_wr_decode.sv
module lmode_wr_decode
  import lmode_pkg::*;
#(
  parameter int unsigned         MSR_W   = 32,
  parameter logic [MSR_W-1:0]    EFER_ID = 'hC000_0080
) (
  input  logic             valid_i,
  input  logic [2:0]       sel_i,
  input  logic [MSR_W-1:0] msr_i,
  output wr_hit_t          hit_o
);

  always_comb begin
    hit_o = '0;
    if (valid_i) begin
      case (wr_sel_e'(sel_i))
        SEL_CR0: hit_o.cr0  = 1'b1;
        SEL_CR3: hit_o.cr3  = 1'b1;
        SEL_CR4: hit_o.cr4  = 1'b1;
        SEL_MSR: hit_o.efer = (msr_i == EFER_ID);
        SEL_CSL: hit_o.csl  = 1'b1;
        default: hit_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/lmode_rule_chk.sv
module lmode_rule_chk (
  input  logic hit_cr0_i,
  input  logic hit_cr4_i,
  input  logic hit_efer_i,
  input  logic new_pg_i,
  input  logic new_pae_i,
  input  logic new_lme_i,
  input  logic cur_pg_i,
  input  logic cur_pae_i,
  input  logic cur_lme_i,
  input  logic cur_lma_i,
  input  logic cur_cs_l_i,
  output logic fault_o
);

  logic lme_flip_paged;
  logic pg_on_no_pae;
  logic pg_on_long_cs;
  logic pae_off_active;
  logic pg_rising;

  assign pg_rising      = hit_cr0_i & new_pg_i & ~cur_pg_i;
  assign lme_flip_paged = hit_efer_i & (new_lme_i ^ cur_lme_i) & cur_pg_i;
  assign pg_on_no_pae   = pg_rising & cur_lme_i & ~cur_pae_i;
  assign pg_on_long_cs  = pg_rising & cur_lme_i & cur_cs_l_i;
  assign pae_off_active = hit_cr4_i & ~new_pae_i & cur_pae_i & cur_lma_i;

  assign fault_o = lme_flip_paged | pg_on_no_pae | pg_on_long_cs | pae_off_active;

endmodule

// File: rtl/lmode_next_state.sv
module lmode_next_state
  import lmode_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LEGACY_W = 32
) (
  input  wr_hit_t           hit_i,
  input  logic              accept_i,
  input  logic              mode64_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] cr0_i,
  input  logic [DATA_W-1:0] cr3_i,
  input  logic [DATA_W-1:0] cr4_i,
  input  logic [DATA_W-1:0] efer_i,
  input  logic              cs_l_i,
  output logic [DATA_W-1:0] cr0_o,
  output logic [DATA_W-1:0] cr3_o,
  output logic [DATA_W-1:0] cr4_o,
  output logic [DATA_W-1:0] efer_o,
  output logic              cs_l_o
);

  logic [DATA_W-1:0] cr3_wr;
  logic [DATA_W-1:0] efer_base;
  logic              lma_n;

  // page-base width limit outside 64-bit mode
  generate
    if (LEGACY_W < DATA_W) begin : g_cr3_trim
      localparam logic [DATA_W-1:0] LEG_MASK = {{(DATA_W-LEGACY_W){1'b0}}, {LEGACY_W{1'b1}}};
      assign cr3_wr = mode64_i ? data_i : (data_i & LEG_MASK);
    end else begin : g_cr3_full
      assign cr3_wr = data_i;
    end
  endgenerate

  always_comb begin
    lma_n = efer_i[EFER_LMA_BIT];
    if (accept_i && hit_i.cr0) begin
      if (!data_i[CR0_PG_BIT])     lma_n = 1'b0;
      else if (!cr0_i[CR0_PG_BIT]) lma_n = efer_i[EFER_LME_BIT];
    end
  end

  always_comb begin
    cr0_o     = (accept_i && hit_i.cr0)  ? data_i : cr0_i;
    cr3_o     = (accept_i && hit_i.cr3)  ? cr3_wr : cr3_i;
    cr4_o     = (accept_i && hit_i.cr4)  ? data_i : cr4_i;
    efer_base = (accept_i && hit_i.efer) ? data_i : efer_i;
    cs_l_o    = (accept_i && hit_i.csl)  ? data_i[0] : cs_l_i;
    efer_o    = efer_base;
    efer_o[EFER_LMA_BIT] = lma_n;
  end

endmodule

// File: rtl/lmode_ctl_unit.sv
module lmode_ctl_unit
  import lmode_pkg::*;
#(
  parameter int unsigned          DATA_W   = 64,
  parameter int unsigned          LEGACY_W = 32,
  parameter int unsigned          MSR_W    = 32,
  parameter logic [MSR_W-1:0]     EFER_ID  = 'hC000_0080,
  parameter logic [DATA_W-1:0]    CR0_RST  = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [MSR_W-1:0]  wr_msr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] cr0_o,
  output logic [DATA_W-1:0] cr3_o,
  output logic [DATA_W-1:0] cr4_o,
  output logic [DATA_W-1:0] efer_o,
  output logic              cs_l_o,
  output logic              mode64_o,
  output logic              gp_fault_o
);

  wr_hit_t           hit;
  logic              fault;
  logic [DATA_W-1:0] cr0_q, cr3_q, cr4_q, efer_q;
  logic [DATA_W-1:0] cr0_d, cr3_d, cr4_d, efer_d;
  logic              cs_l_q, cs_l_d;
  logic              mode64;

  assign mode64 = efer_q[EFER_LMA_BIT] & cs_l_q;

  lmode_wr_decode #(
    .MSR_W   (MSR_W),
    .EFER_ID (EFER_ID)
  ) u_decode (
    .valid_i (wr_valid_i),
    .sel_i   (wr_sel_i),
    .msr_i   (wr_msr_i),
    .hit_o   (hit)
  );

  lmode_rule_chk u_rules (
    .hit_cr0_i  (hit.cr0),
    .hit_cr4_i  (hit.cr4),
    .hit_efer_i (hit.efer),
    .new_pg_i   (wr_data_i[CR0_PG_BIT]),
    .new_pae_i  (wr_data_i[CR4_PAE_BIT]),
    .new_lme_i  (wr_data_i[EFER_LME_BIT]),
    .cur_pg_i   (cr0_q[CR0_PG_BIT]),
    .cur_pae_i  (cr4_q[CR4_PAE_BIT]),
    .cur_lme_i  (efer_q[EFER_LME_BIT]),
    .cur_lma_i  (efer_q[EFER_LMA_BIT]),
    .cur_cs_l_i (cs_l_q),
    .fault_o    (fault)
  );

  lmode_next_state #(
    .DATA_W   (DATA_W),
    .LEGACY_W (LEGACY_W)
  ) u_next (
    .hit_i    (hit),
    .accept_i (~fault),
    .mode64_i (mode64),
    .data_i   (wr_data_i),
    .cr0_i    (cr0_q),
    .cr3_i    (cr3_q),
    .cr4_i    (cr4_q),
    .efer_i   (efer_q),
    .cs_l_i   (cs_l_q),
    .cr0_o    (cr0_d),
    .cr3_o    (cr3_d),
    .cr4_o    (cr4_d),
    .efer_o   (efer_d),
    .cs_l_o   (cs_l_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q  <= CR0_RST;
      cr3_q  <= '0;
      cr4_q  <= '0;
      efer_q <= '0;
      cs_l_q <= 1'b0;
    end else begin
      cr0_q  <= cr0_d;
      cr3_q  <= cr3_d;
      cr4_q  <= cr4_d;
      efer_q <= efer_d;
      cs_l_q <= cs_l_d;
    end
  end

  assign cr0_o      = cr0_q;
  assign cr3_o      = cr3_q;
  assign cr4_o      = cr4_q;
  assign efer_o     = efer_q;
  assign cs_l_o     = cs_l_q;
  assign mode64_o   = mode64;
  assign gp_fault_o = fault;

  // R2: at most one target per request
  a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  // R9
  a_r9_fault_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> wr_valid_i);

  a_r9_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |=> ($stable(cr0_o) && $stable(cr3_o) && $stable(cr4_o)
                    && $stable(efer_o) && $stable(cs_l_o)));

  // R3
  a_r3_lme_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr0_o[CR0_PG_BIT] |=> $stable(efer_o[EFER_LME_BIT]));

  // R6
  a_r6_pae_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (efer_o[EFER_LMA_BIT] && cr4_o[CR4_PAE_BIT]) |=> cr4_o[CR4_PAE_BIT]);

  // R7
  a_r7_lma_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit.cr0 && !wr_data_i[CR0_PG_BIT]) |=> !efer_o[EFER_LMA_BIT]);

  // R10
  a_r10_lma_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    efer_o[EFER_LMA_BIT] |-> (cr0_o[CR0_PG_BIT] && efer_o[EFER_LME_BIT]
                              && cr4_o[CR4_PAE_BIT]));

  // R8
  generate
    if (LEGACY_W < DATA_W) begin : g_cr3_chk
      a_r8_cr3_trim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit.cr3 && !mode64_o) |=> (cr3_o[DATA_W-1:LEGACY_W] == '0));
    end
  endgenerate

endmodule

// File: tb/lmode_ctl_unit_tb.sv
`timescale 1ns/1ps
module lmode_ctl_unit_tb_top;

  localparam logic [31:0] EFER_ID = 32'hC000_0080;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_msr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] cr0_o, cr3_o, cr4_o, efer_o;
  logic        cs_l_o, mode64_o, gp_fault_o;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  lmode_ctl_unit dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_sel_i   (wr_sel_i),
    .wr_msr_i   (wr_msr_i),
    .wr_data_i  (wr_data_i),
    .cr0_o      (cr0_o),
    .cr3_o      (cr3_o),
    .cr4_o      (cr4_o),
    .efer_o     (efer_o),
    .cs_l_o     (cs_l_o),
    .mode64_o   (mode64_o),
    .gp_fault_o (gp_fault_o)
  );

  typedef struct {
    logic        fault;
    logic [63:0] cr0, cr3, cr4, efer;
    logic        csl;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t pend;
  bit   have_pend = 0;

  logic [63:0] m_cr0 = 64'h10, m_cr3 = '0, m_cr4 = '0, m_efer = '0;
  logic        m_csl = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // driver: reference model from the requirements, push expectation, drive
  task automatic wr(input logic [2:0] sel, input logic [31:0] msr,
                    input logic [63:0] d, input string tag);
    exp_t e;
    logic f;
    f = 1'b0;
    case (sel)
      3'd0: f = d[31] && !m_cr0[31] && m_efer[8] && (!m_cr4[5] || m_csl);
      3'd2: f = !d[5] && m_cr4[5] && m_efer[10];
      3'd3: f = (msr == EFER_ID) && (d[8] != m_efer[8]) && m_cr0[31];
      default: f = 1'b0;
    endcase
    if (!f) begin
      case (sel)
        3'd0: begin
          if (!d[31]) m_efer[10] = 1'b0;
          else if (!m_cr0[31]) m_efer[10] = m_efer[8];
          m_cr0 = d;
        end
        3'd1: m_cr3 = (m_efer[10] && m_csl) ? d : {32'h0, d[31:0]};
        3'd2: m_cr4 = d;
        3'd3: if (msr == EFER_ID) m_efer = {d[63:11], m_efer[10], d[9:0]};
        3'd4: m_csl = d[0];
        default: ;
      endcase
    end
    e.fault = f; e.cr0 = m_cr0; e.cr3 = m_cr3; e.cr4 = m_cr4;
    e.efer = m_efer; e.csl = m_csl; e.tag = tag;
    q.push_back(e);
    @(posedge clk_i); #1;
    wr_valid_i = 1'b1; wr_sel_i = sel; wr_msr_i = msr; wr_data_i = d;
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0;
  endtask

  // monitor: sample mid-cycle
  initial begin
    forever begin
      @(negedge clk_i);
      if (have_pend) begin
        chk(pend.tag, "cr0", cr0_o, pend.cr0);
        chk(pend.tag, "cr3", cr3_o, pend.cr3);
        chk(pend.tag, "cr4", cr4_o, pend.cr4);
        chk(pend.tag, "efer", efer_o, pend.efer);
        chk(pend.tag, "cs_l", {63'b0, cs_l_o}, {63'b0, pend.csl});
        chk({pend.tag, "/R8"}, "mode64", {63'b0, mode64_o},
            {63'b0, pend.efer[10] & pend.csl});
        if (efer_o[10])
          chk("R10", "pg/lme/pae", {61'b0, cr0_o[31], efer_o[8], cr4_o[5]}, 64'h7);
        have_pend = 0;
      end
      if (rst_ni && wr_valid_i && q.size() > 0) begin
        pend = q.pop_front();
        chk(pend.fault ? {pend.tag, "/R9"} : pend.tag, "fault",
            {63'b0, gp_fault_o}, {63'b0, pend.fault});
        have_pend = 1;
      end else if (rst_ni) begin
        chk("R9", "idle fault", {63'b0, gp_fault_o}, 64'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "cr0", cr0_o, 64'h10);
    chk("R1", "cr3", cr3_o, 64'h0);
    chk("R1", "cr4", cr4_o, 64'h0);
    chk("R1", "efer", efer_o, 64'h0);
    chk("R1", "cs_l/fault", {62'b0, cs_l_o, gp_fault_o}, 64'h0);
    rst_ni = 1'b1;

    wr(3'd3, 32'hC000_0081, 64'h100, "R2");           // other MSR ignored
    wr(3'd2, 32'h0, 64'h20, "R2");
    wr(3'd1, 32'h0, 64'hFFFF_FFFF_1234_5000, "R8");    // trimmed
    wr(3'd3, EFER_ID, 64'h500, "R7");                  // bit 10 ignored
    wr(3'd4, 32'h0, 64'h1, "R2");
    wr(3'd0, 32'h0, 64'h8000_0011, "R5");              // fault: long CS
    wr(3'd4, 32'h0, 64'h0, "R2");
    idle();
    wr(3'd2, 32'h0, 64'h0, "R4");
    wr(3'd0, 32'h0, 64'h8000_0011, "R4");              // fault: no PAE
    wr(3'd2, 32'h0, 64'h20, "R2");
    wr(3'd0, 32'h0, 64'h8000_0011, "R7");              // LMA set
    wr(3'd3, EFER_ID, 64'h0, "R3");                    // fault
    wr(3'd3, EFER_ID, 64'h100, "R3");                  // no change, ok
    wr(3'd2, 32'h0, 64'h0, "R6");                      // fault
    wr(3'd1, 32'h0, 64'hABCD_0000_0000_1000, "R8");    // compat: trimmed
    wr(3'd4, 32'h0, 64'h1, "R2");
    wr(3'd1, 32'h0, 64'hABCD_0000_0000_1000, "R8");    // 64-bit: full
    wr(3'd3, EFER_ID, 64'h400, "R7");                  // fault, PG=1
    wr(3'd0, 32'h0, 64'h11, "R7");                     // LMA clear
    wr(3'd3, EFER_ID, 64'h0, "R3");                    // allowed, PG=0
    wr(3'd0, 32'h0, 64'h8000_0011, "R7");              // legacy paging
    wr(3'd3, EFER_ID, 64'h100, "R3");                  // fault
    wr(3'd1, 32'h0, 64'h1_0000_2000, "R8");            // trimmed
    idle();
    repeat (3) @(posedge clk_i);
    wait (q.size() == 0 && !have_pend);
    @(negedge clk_i);
    summary();
    $finish;
  end

endmodule